// File: doc/BRIEF.md
# Core Deep Idle Sequencer

This block steps a single core into and out of its deep idle states, C6 and C7. A core asks for deep idle in one of two ways. It can issue an I/O read that hits one of two idle-level addresses. It can also issue a wait-type request whose operand names the target state. Both forms lead to one shared sequence, and C7 differs from C6 only in the state code reported while the core is powered down.

The sequence has a fixed order:

1. A local SRAM copy engine saves the architectural state.
2. Once the save is done, the block asks for core power to be removed.
3. The block rests in the off state until a wake pulse arrives.
4. On wake, it asks for power to return. Once power is good again, it asks the copy engine to restore the state and then returns to active.

A wake that arrives while the save is running cancels the entry. A watchdog counter, with a limit set at run time, flags a power acknowledge that never arrives.

Top module: `core_idle_seq`

## Requirements
- R1: While rst is high and in the cycle after it falls, the block is active. In that state `pwr_en`=1, `save_req`=0, `restore_req`=0, `pwr_err`=0 and `core_cstate`=0.
- R2: Deep idle is requested by an I/O read (`io_rd_valid`=1) to one of two addresses, both parameters. Address LVL3_ADDR (default 16'h0414) requests C6 and LVL4_ADDR (default 16'h0415) requests C7. A read to any other address is ignored.
- R3: A wait request (`wait_valid`=1) with `wait_cstate`=6 requests C6 and with `wait_cstate`=7 requests C7. Any other operand is ignored. If an I/O request and a wait request arrive in the same cycle, the I/O request decides the target.
- R4: `save_req` rises in the cycle after a request is accepted. It stays high until `save_done` is seen, and `pwr_en` stays 1 throughout the save.
- R5: `pwr_en` falls in the cycle after `save_done` is seen, and never earlier.
- R6: When `pwr_good` is seen low while power-off is requested, the block enters the off state. `core_cstate` reads 6 or 7 (the accepted target) only in that state and 0 at all other times.
- R7: A `wake` pulse in the off state raises `pwr_en` in the next cycle. `restore_req` rises only in the cycle after `pwr_good` is seen high, and is held until `restore_done`, after which the block is active again.
- R8: A `wake` during the save aborts the entry. When `save_done` arrives the block returns to active with `pwr_en` still 1.
- R9: A `wake` during the power-off request is remembered. The block spends exactly one cycle in the off state and then requests power again.
- R10: With `ack_timeout`=T (T>0), if the awaited `pwr_good` level is missing for T cycles after a power request changes, `pwr_err` rises and stays high until reset. T=0 disables the check.
- R11: Requests that arrive while the block is not active are ignored.
- R12: A C7 entry follows the same save, power-off, off, power-on and restore order as C6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd_valid | input | 1 | I/O read strobe |
| io_rd_addr | input | ADDR_W | I/O read address |
| wait_valid | input | 1 | Wait-type idle request strobe |
| wait_cstate | input | 4 | Target state operand of the wait request |
| wake | input | 1 | Wake event pulse (for example an interrupt) |
| save_req | output | 1 | Request to the copy engine to save state |
| save_done | input | 1 | Save finished |
| restore_req | output | 1 | Request to the copy engine to restore state |
| restore_done | input | 1 | Restore finished |
| pwr_en | output | 1 | Core power request (1 = power on) |
| pwr_good | input | 1 | Core power acknowledge (1 = power good) |
| ack_timeout | input | TMO_W | Cycles allowed for a power acknowledge, 0 = off |
| pwr_err | output | 1 | Sticky power acknowledge timeout flag |
| core_cstate | output | 3 | Achieved core state code: 0, 6 or 7 |

## Verification
The bench targets the ordering edges of the sequence:

- **Save held long before `save_done`.** A design that cut power early would drop `pwr_en` during the save.
- **Restore requested late.** A design that restored before power was back would raise `restore_req` while `pwr_good` is still low.
- **Wake timing.** Wake pulses are placed in the save window and in the power-off window. A lost pending wake would leave the core parked in the off state. A lost abort would power the core down anyway.
- **Decode edges.** The bench drives same-cycle I/O and wait requests, off-address reads, out-of-range operands and requests during a busy sequence. A wrong decode or a missing active-state guard shows up directly on `core_cstate`.
- **Timeout counter.** The counter is probed one cycle before and at its limit, which exposes an off-by-one error.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

    // One-hot sequencer states
    typedef enum logic [5:0] {
        ST_ACTIVE   = 6'b000001,
        ST_SAVE     = 6'b000010,
        ST_PWR_OFF  = 6'b000100,
        ST_OFF      = 6'b001000,
        ST_PWR_ON   = 6'b010000,
        ST_RESTORE  = 6'b100000
    } seq_state_e;

    localparam logic [2:0] CODE_C0 = 3'd0;
    localparam logic [2:0] CODE_C6 = 3'd6;
    localparam logic [2:0] CODE_C7 = 3'd7;

    localparam int WAIT_W = 4;
    localparam logic [WAIT_W-1:0] WAIT_OP_C6 = 4'd6;
    localparam logic [WAIT_W-1:0] WAIT_OP_C7 = 4'd7;

    // Decoded idle request: deep = 1 selects C7, 0 selects C6
    typedef struct packed {
        logic valid;
        logic deep;
    } idle_req_t;

    function automatic logic [2:0] target_code(input logic deep);
        return deep ? CODE_C7 : CODE_C6;
    endfunction

    function automatic logic is_power_phase(input seq_state_e s);
        return (s == ST_PWR_OFF) || (s == ST_PWR_ON);
    endfunction

endpackage

// File: rtl/cdi_req_decode.sv
module cdi_req_decode
    import cdi_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LVL3_ADDR = 16'h0414,
    parameter logic [ADDR_W-1:0] LVL4_ADDR = 16'h0415
) (
    input  logic              io_rd_valid,
    input  logic [ADDR_W-1:0] io_rd_addr,
    input  logic              wait_valid,
    input  logic [WAIT_W-1:0] wait_cstate,
    output idle_req_t         req
);
    idle_req_t io_req;
    idle_req_t wt_req;

    always_comb begin
        io_req.valid = io_rd_valid && ((io_rd_addr == LVL3_ADDR) || (io_rd_addr == LVL4_ADDR));
        io_req.deep  = (io_rd_addr == LVL4_ADDR);
        wt_req.valid = wait_valid && ((wait_cstate == WAIT_OP_C6) || (wait_cstate == WAIT_OP_C7));
        wt_req.deep  = (wait_cstate == WAIT_OP_C7);
    end

    // I/O decode has priority over the wait request
    always_comb begin
        if (io_req.valid) req = io_req;
        else if (wt_req.valid) req = wt_req;
        else req = '0;
    end
endmodule

// File: rtl/cdi_pwr_timer.sv
module cdi_pwr_timer #(
    parameter int TMO_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             waiting,
    input  logic [TMO_W-1:0] limit,
    output logic             err
);
    logic [TMO_W-1:0] cnt_q;
    logic             hit;

    assign hit = waiting && (limit != '0) && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (waiting && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else if (hit) err <= 1'b1;
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst) !$fell(err));
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
    import cdi_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LVL3_ADDR = 16'h0414,
    parameter logic [ADDR_W-1:0] LVL4_ADDR = 16'h0415,
    parameter int                TMO_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_rd_valid,
    input  logic [ADDR_W-1:0] io_rd_addr,
    input  logic              wait_valid,
    input  logic [3:0]        wait_cstate,
    input  logic              wake,
    output logic              save_req,
    input  logic              save_done,
    output logic              restore_req,
    input  logic              restore_done,
    output logic              pwr_en,
    input  logic              pwr_good,
    input  logic [TMO_W-1:0]  ack_timeout,
    output logic              pwr_err,
    output logic [2:0]        core_cstate
);
    seq_state_e state_q, state_d;
    idle_req_t  req;
    logic       deep_q;
    logic       wake_pend_q;
    logic       ack_missing;

    cdi_req_decode #(
        .ADDR_W   (ADDR_W),
        .LVL3_ADDR(LVL3_ADDR),
        .LVL4_ADDR(LVL4_ADDR)
    ) u_dec (
        .io_rd_valid(io_rd_valid),
        .io_rd_addr (io_rd_addr),
        .wait_valid (wait_valid),
        .wait_cstate(wait_cstate),
        .req        (req)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:  if (req.valid) state_d = ST_SAVE;
            ST_SAVE:    if (save_done) state_d = (wake || wake_pend_q) ? ST_ACTIVE : ST_PWR_OFF;
            ST_PWR_OFF: if (!pwr_good) state_d = ST_OFF;
            ST_OFF:     if (wake || wake_pend_q) state_d = ST_PWR_ON;
            ST_PWR_ON:  if (pwr_good) state_d = ST_RESTORE;
            ST_RESTORE: if (restore_done) state_d = ST_ACTIVE;
            default:    state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_ACTIVE;
            deep_q      <= 1'b0;
            wake_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACTIVE && req.valid) deep_q <= req.deep;
            if (state_d == ST_ACTIVE || state_d == ST_PWR_ON) wake_pend_q <= 1'b0;
            else if (wake && (state_q == ST_SAVE || state_q == ST_PWR_OFF)) wake_pend_q <= 1'b1;
        end
    end

    assign ack_missing = (state_q == ST_PWR_OFF) ? pwr_good : !pwr_good;

    cdi_pwr_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .clear  (!is_power_phase(state_q)),
        .waiting(is_power_phase(state_q) && ack_missing),
        .limit  (ack_timeout),
        .err    (pwr_err)
    );

    assign save_req    = (state_q == ST_SAVE);
    assign restore_req = (state_q == ST_RESTORE);
    assign pwr_en      = !((state_q == ST_PWR_OFF) || (state_q == ST_OFF));
    assign core_cstate = (state_q == ST_OFF) ? target_code(deep_q) : CODE_C0;

    // R1
    state_onehot_chk: assert property (@(posedge clk) disable iff (rst) $countones(state_q) == 1);
    // R4
    save_hold_chk: assert property (@(posedge clk) disable iff (rst)
        save_req && !save_done && !wake |=> save_req || !save_req && pwr_en);
    // R4
    save_power_on_chk: assert property (@(posedge clk) disable iff (rst) save_req |-> pwr_en);
    // R5
    off_after_save_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> $past(save_done) && $past(save_req));
    // R7
    restore_after_power_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(restore_req) |-> $past(pwr_good) && pwr_en);
    // R7
    restore_hold_chk: assert property (@(posedge clk) disable iff (rst)
        restore_req && !restore_done |=> restore_req);
    // R6
    cstate_off_chk: assert property (@(posedge clk) disable iff (rst) (core_cstate != 3'd0) |-> !pwr_en);
    // R4
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst) !(save_req && restore_req));
endmodule

// File: tb/core_idle_seq_test.sv
module core_idle_seq_test;
    localparam int ADDR_W = 16;
    localparam int TMO_W  = 12;
    localparam logic [15:0] A3 = 16'h0414;
    localparam logic [15:0] A4 = 16'h0415;

    logic clk = 1'b0;
    logic rst;
    logic io_rd_valid, wait_valid, wake, save_done, restore_done, pwr_good;
    logic [ADDR_W-1:0] io_rd_addr;
    logic [3:0] wait_cstate;
    logic [TMO_W-1:0] ack_timeout;
    logic save_req, restore_req, pwr_en, pwr_err;
    logic [2:0] core_cstate;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    core_idle_seq #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) uut (
        .clk(clk), .rst(rst),
        .io_rd_valid(io_rd_valid), .io_rd_addr(io_rd_addr),
        .wait_valid(wait_valid), .wait_cstate(wait_cstate),
        .wake(wake),
        .save_req(save_req), .save_done(save_done),
        .restore_req(restore_req), .restore_done(restore_done),
        .pwr_en(pwr_en), .pwr_good(pwr_good),
        .ack_timeout(ack_timeout), .pwr_err(pwr_err),
        .core_cstate(core_cstate)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic clear_inputs();
        io_rd_valid = 0; io_rd_addr = '0; wait_valid = 0; wait_cstate = '0;
        wake = 0; save_done = 0; restore_done = 0;
    endtask

    // Full entry/exit, request already driven for one cycle
    task automatic run_sequence(input logic [2:0] exp_code, input string tag);
        step();
        clear_inputs();
        check({tag, " save_req R4"}, save_req, 1);
        step(3);
        check({tag, " save held R4"}, save_req, 1);
        check({tag, " power on during save R5"}, pwr_en, 1);
        save_done = 1;
        step();
        save_done = 0;
        check({tag, " pwr_en fell R5"}, pwr_en, 0);
        check({tag, " not yet off R6"}, core_cstate, 0);
        pwr_good = 0;
        step();
        check({tag, " off code R6"}, core_cstate, exp_code);
        io_rd_valid = 1; io_rd_addr = A3;
        step(2);
        io_rd_valid = 0;
        check({tag, " busy request ignored R11"}, core_cstate, exp_code);
        wake = 1;
        step();
        wake = 0;
        check({tag, " power back R7"}, pwr_en, 1);
        check({tag, " code cleared R6"}, core_cstate, 0);
        step(2);
        check({tag, " no restore before power R7"}, restore_req, 0);
        pwr_good = 1;
        step();
        check({tag, " restore_req R7"}, restore_req, 1);
        step(2);
        check({tag, " restore held R7"}, restore_req, 1);
        restore_done = 1;
        step();
        restore_done = 0;
        check({tag, " back active R7"}, restore_req, 0);
        check({tag, " back active save R12"}, save_req, 0);
    endtask

    task automatic t_reset();
        rst = 1; clear_inputs(); pwr_good = 1; ack_timeout = 12'd20;
        step(3);
        check("R1 pwr_en", pwr_en, 1);
        check("R1 save_req", save_req, 0);
        rst = 0;
        step();
        check("R1 restore_req", restore_req, 0);
        check("R1 pwr_err", pwr_err, 0);
        check("R1 cstate", core_cstate, 0);
    endtask

    task automatic t_io_c6();
        io_rd_valid = 1; io_rd_addr = A3;
        run_sequence(3'd6, "R2 io C6");
    endtask

    task automatic t_io_c7();
        io_rd_valid = 1; io_rd_addr = A4;
        run_sequence(3'd7, "R12 io C7");
    endtask

    task automatic t_wait();
        wait_valid = 1; wait_cstate = 4'd6;
        run_sequence(3'd6, "R3 wait C6");
        wait_valid = 1; wait_cstate = 4'd7;
        run_sequence(3'd7, "R3 wait C7");
        io_rd_valid = 1; io_rd_addr = A4; wait_valid = 1; wait_cstate = 4'd6;
        run_sequence(3'd7, "R3 io priority");
    endtask

    task automatic t_ignored();
        io_rd_valid = 1; io_rd_addr = 16'h0416;
        step();
        io_rd_valid = 0;
        check("R2 wrong addr ignored", save_req, 0);
        wait_valid = 1; wait_cstate = 4'd3;
        step();
        wait_valid = 0;
        check("R3 bad operand ignored", save_req, 0);
        wait_cstate = 4'd8; wait_valid = 1;
        step();
        wait_valid = 0;
        check("R3 operand 8 ignored", save_req, 0);
    endtask

    task automatic t_abort();
        io_rd_valid = 1; io_rd_addr = A3;
        step();
        clear_inputs();
        check("R8 saving", save_req, 1);
        wake = 1;
        step();
        wake = 0;
        check("R8 save continues", save_req, 1);
        step(2);
        save_done = 1;
        step();
        save_done = 0;
        check("R8 abort keeps power", pwr_en, 1);
        check("R8 abort save_req low", save_req, 0);
        check("R8 abort cstate", core_cstate, 0);
        step(2);
        check("R8 stays active", pwr_en, 1);
    endtask

    task automatic t_pending_wake();
        io_rd_valid = 1; io_rd_addr = A4;
        step();
        clear_inputs();
        save_done = 1;
        step();
        save_done = 0;
        check("R9 power off requested", pwr_en, 0);
        wake = 1;
        step();
        wake = 0;
        pwr_good = 0;
        step();
        check("R9 one off cycle", core_cstate, 7);
        step();
        check("R9 power requested again", pwr_en, 1);
        pwr_good = 1;
        step();
        restore_done = 1;
        step();
        restore_done = 0;
        check("R9 back active", restore_req, 0);
    endtask

    task automatic t_timeout();
        ack_timeout = 12'd5;
        wait_valid = 1; wait_cstate = 4'd6;
        step();
        clear_inputs();
        save_done = 1;
        step();
        save_done = 0;
        check("R10 pwr_en low", pwr_en, 0);
        step(4);
        check("R10 no error before limit", pwr_err, 0);
        step();
        check("R10 error at limit", pwr_err, 1);
        pwr_good = 0;
        step();
        check("R10 off reached", core_cstate, 6);
        wake = 1;
        step();
        wake = 0;
        pwr_good = 1;
        step();
        restore_done = 1;
        step();
        restore_done = 0;
        check("R10 error sticky", pwr_err, 1);
        check("R10 sequence completes", pwr_en, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_io_c6();
        t_io_c7();
        t_wait();
        t_ignored();
        t_abort();
        t_pending_wake();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule